// File: doc/BRIEF.md
# Four-Phase Read Handshake Responder

This block is the memory-side agent of a clockless read protocol. Its requester has no shared clock with it. Address and data travel over the same bidirectional data lines at different times. A read takes two full four-phase interlocks.

In the first interlock the requester raises its request line with an address on the bus. The responder captures the address and raises its acknowledge. It holds the acknowledge until the request falls.

In the second interlock the responder looks the word up in a small internal table after a fixed number of cycles. It drives the word onto the bus and raises a data-ready strobe. It keeps both up until the requester acknowledges the data. It then releases the bus and waits for the requester's acknowledge to drop before it accepts another request.

The requester's control lines are brought into the local clock through two-flop synchronisers. The shared bus appears as an input vector, an output vector and an output enable.

Top module: `ahs_read_responder`

## Requirements
- R1: While reset is asserted, and after it is released, `ack_out`, `rdy_out` and `bus_oe` are low until a request arrives.
- R2: `ack_out` rises exactly 3 clock cycles after `req_in` rises. The address is taken from `bus_in[ADDR_W-1:0]` while the request is seen.
- R3: `ack_out` stays high for as long as `req_in` stays high, and `rdy_out` stays low throughout that time.
- R4: `rdy_out` rises exactly LAT+3 clock cycles after `req_in` falls, and `ack_out` is low by then.
- R5: While `rdy_out` is high, `bus_out` carries the table word for the captured address a. That word is (a*MUL + ADD) mod 2^DATA_W, with MUL=29 and ADD=90 by default.
- R6: `bus_oe` is high exactly when `rdy_out` is high, so the responder never drives the bus during the address phase.
- R7: `bus_out` is stable while `rdy_out` is high. Values placed on `bus_in` after the address capture do not change the returned word.
- R8: `rdy_out` stays high while `ack_in` is low, and falls together with `bus_oe` exactly 3 cycles after `ack_in` rises.
- R9: A new request is not acknowledged while `ack_in` from the previous read is still high. Once `ack_in` falls, a pending request is acknowledged.
- R10: `ack_out` and `rdy_out` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock of the responder |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_in | input | 1 | Read request from the requester (asynchronous) |
| ack_in | input | 1 | Data acknowledge from the requester (asynchronous) |
| bus_in | input | DATA_W | Value seen on the shared data lines |
| ack_out | output | 1 | Address acknowledge to the requester |
| rdy_out | output | 1 | Data-ready strobe to the requester |
| bus_out | output | DATA_W | Word driven onto the shared data lines |
| bus_oe | output | 1 | Output enable for `bus_out` onto the shared lines |

## Verification
Four behaviours are checked by the assertions on every cycle:
- acknowledge and data-ready are never high together;
- the acknowledge is held while the synchronised request is high;
- the data-ready strobe and the driven word are held until the synchronised data acknowledge arrives;
- the output enable follows data-ready and the fetch counter stays in range.

The scenarios show what the assertions cannot:
- exact cycle distances across the synchronisers and the fetch delay;
- the correct word for every address;
- immunity to bus changes after capture;
- refusal of a new request while the previous acknowledge is still high.

// File: rtl/ahs_pkg.sv
package ahs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR_ACK,
    ST_WAIT_REQ_LOW,
    ST_FETCH,
    ST_DATA_VALID,
    ST_WAIT_ACK_LOW
  } hs_state_t;
endpackage

// File: rtl/ahs_sync.sv
module ahs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_l,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_async;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/ahs_word_store.sv
module ahs_word_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int MUL    = 29,
  parameter int ADD    = 90
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam int VAL = i * MUL + ADD;
    assign tbl[i] = VAL[DATA_W-1:0];
  end

  assign word = tbl[addr];
endmodule

// File: rtl/ahs_read_responder.sv
module ahs_read_responder
  import ahs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int LAT    = 3,
  parameter int MUL    = 29,
  parameter int ADD    = 90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_in,
  input  logic              ack_in,
  input  logic [DATA_W-1:0] bus_in,
  output logic              ack_out,
  output logic              rdy_out,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LAT - 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_l    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_l    <= rst_meta;
    end
  end

  logic req_s, ack_s;
  ahs_sync #(.W(2), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst_l  (rst_l),
    .d_async({req_in, ack_in}),
    .q_sync ({req_s, ack_s})
  );

  hs_state_t         st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              ack_q, ack_n, rdy_q, rdy_n, oe_q, oe_n;
  logic              addr_en, data_en, cnt_en;
  logic [DATA_W-1:0] tbl_word;

  ahs_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MUL(MUL), .ADD(ADD)) u_store (
    .addr(addr_q),
    .word(tbl_word)
  );

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    cnt_en  = 1'b0;
    addr_en = 1'b0;
    data_en = 1'b0;
    ack_n   = ack_q;
    rdy_n   = rdy_q;
    oe_n    = oe_q;
    case (st_q)
      ST_IDLE: if (req_s) begin
        addr_en = 1'b1;
        ack_n   = 1'b1;
        st_n    = ST_ADDR_ACK;
      end
      ST_ADDR_ACK: st_n = ST_WAIT_REQ_LOW;
      ST_WAIT_REQ_LOW: if (!req_s) begin
        ack_n  = 1'b0;
        cnt_n  = CNT_LOAD;
        cnt_en = 1'b1;
        st_n   = ST_FETCH;
      end
      ST_FETCH: begin
        if (cnt_q == '0) begin
          data_en = 1'b1;
          rdy_n   = 1'b1;
          oe_n    = 1'b1;
          st_n    = ST_DATA_VALID;
        end else begin
          cnt_n  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_DATA_VALID: if (ack_s) begin
        rdy_n = 1'b0;
        oe_n  = 1'b0;
        st_n  = ST_WAIT_ACK_LOW;
      end
      ST_WAIT_ACK_LOW: if (!ack_s) st_n = ST_IDLE;
      default: begin
        st_n  = ST_IDLE;
        ack_n = 1'b0;
        rdy_n = 1'b0;
        oe_n  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      ack_q  <= 1'b0;
      rdy_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      st_q  <= st_n;
      ack_q <= ack_n;
      rdy_q <= rdy_n;
      oe_q  <= oe_n;
      if (cnt_en)  cnt_q  <= cnt_n;
      if (addr_en) addr_q <= bus_in[ADDR_W-1:0];
      if (data_en) data_q <= tbl_word;
    end
  end

  assign ack_out = ack_q;
  assign rdy_out = rdy_q;
  assign bus_oe  = oe_q;
  assign bus_out = data_q;

  AST_ACK_RDY_EXCL: assert property (@(posedge clk) disable iff (!rst_l)
    !(ack_q && rdy_q)); // R10
  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_l)
    (ack_q && req_s) |=> ack_q); // R3
  AST_RDY_HELD: assert property (@(posedge clk) disable iff (!rst_l)
    (rdy_q && !ack_s) |=> rdy_q); // R8
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_l)
    (rdy_q && $past(rdy_q)) |-> $stable(data_q)); // R7
  AST_OE_TRACKS_RDY: assert property (@(posedge clk) disable iff (!rst_l)
    oe_q == rdy_q); // R6
  AST_FETCH_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_l)
    (st_q == ST_FETCH) |-> (int'(cnt_q) < LAT)); // R4
endmodule

// File: tb/tb_ahs_read_responder.sv
module tb_ahs_read_responder;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int LAT    = 3;
  localparam int MUL    = 29;
  localparam int ADD    = 90;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_in = 1'b0, ack_in = 1'b0;
  logic [DATA_W-1:0] bus_in = '0;
  logic ack_out, rdy_out, bus_oe;
  logic [DATA_W-1:0] bus_out;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  ahs_read_responder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT), .MUL(MUL), .ADD(ADD)) dut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .ack_in(ack_in), .bus_in(bus_in),
    .ack_out(ack_out), .rdy_out(rdy_out), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int word_of(input int a);
    return (a * MUL + ADD) % (1 << DATA_W);
  endfunction

  task automatic wait_cnt(input int which, input bit lvl, output int n);
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      n++;
      if (which == 0 && ack_out == lvl) return;
      if (which == 1 && rdy_out == lvl) return;
    end
  endtask

  task automatic one_read(input int a, input int hold, input bit scramble);
    int n;
    logic [DATA_W-1:0] first;
    @(negedge clk);
    bus_in = DATA_W'(a);
    req_in = 1'b1;
    wait_cnt(0, 1'b1, n);
    chk(n == 3, "R2 ack delay", n, 3);
    chk(bus_oe == 1'b0, "R6 no drive in addr phase", bus_oe, 0);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(ack_out && !rdy_out, "R3 ack held", {ack_out, rdy_out}, 2);
    end
    req_in = 1'b0;
    if (scramble) bus_in = ~DATA_W'(a);
    else bus_in = '0;
    wait_cnt(1, 1'b1, n);
    chk(n == LAT + 3, "R4 data delay", n, LAT + 3);
    chk(ack_out == 1'b0, "R10 ack low with rdy", ack_out, 0);
    chk(bus_oe == 1'b1, "R6 drive with rdy", bus_oe, 1);
    chk(int'(bus_out) == word_of(a), "R5 word", bus_out, word_of(a));
    first = bus_out;
    for (int h = 0; h < 2 + (a % 3); h++) begin
      @(negedge clk);
      bus_in = DATA_W'(h * 37 + a);
      chk(rdy_out && bus_out == first, "R7 R8 rdy and word held", bus_out, first);
    end
    ack_in = 1'b1;
    wait_cnt(1, 1'b0, n);
    chk(n == 3, "R8 rdy release delay", n, 3);
    chk(bus_oe == 1'b0, "R6 release bus", bus_oe, 0);
    @(negedge clk);
    ack_in = 1'b0;
    repeat (4) @(negedge clk);
    chk(!ack_out && !rdy_out, "R9 idle after read", {ack_out, rdy_out}, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int n;
    repeat (3) @(negedge clk);
    chk(!ack_out && !rdy_out && !bus_oe, "R1 in reset", {ack_out, rdy_out, bus_oe}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!ack_out && !rdy_out && !bus_oe, "R1 after reset", {ack_out, rdy_out, bus_oe}, 0);

    for (int a = 0; a < (1 << ADDR_W); a++) one_read(a, a % 4, a[0]);

    // R9: a new request is held off while the previous data acknowledge remains high
    @(negedge clk);
    bus_in = DATA_W'(9);
    req_in = 1'b1;
    wait_cnt(0, 1'b1, n);
    req_in = 1'b0;
    wait_cnt(1, 1'b1, n);
    ack_in = 1'b1;
    wait_cnt(1, 1'b0, n);
    bus_in = DATA_W'(6);
    req_in = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(ack_out == 1'b0, "R9 no ack while ack_in high", ack_out, 0);
    end
    ack_in = 1'b0;
    wait_cnt(0, 1'b1, n);
    chk(ack_out == 1'b1 && n <= 8, "R9 ack after ack_in low", n, 4);
    req_in = 1'b0;
    wait_cnt(1, 1'b1, n);
    chk(int'(bus_out) == word_of(6), "R5 R9 word after held request", bus_out, word_of(6));
    ack_in = 1'b1;
    wait_cnt(1, 1'b0, n);
    @(negedge clk);
    ack_in = 1'b0;
    repeat (5) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule